// File: doc/BRIEF.md
# Host Transmit Endpoint Control and Status

This block holds the 8-bit control and status register for one host-mode transmit endpoint of a USB controller, together with the event logic that ties the register to handshake outcomes. Software arms a transfer by setting the ready bit. It can request a SETUP token in place of an OUT token, reset the data toggle, and flush the FIFO. A transaction engine reports ACK, NAK, STALL and no-response outcomes as single-cycle strobes. A frame tick paces the NAK timeout.

The block answers each handshake with register side effects and strobes. An ACK advances the data toggle and completes the transfer. A STALL aborts DMA, flushes the FIFO and drops the request. NAKs that last longer than a programmable number of frames halt a bulk endpoint until software clears the timeout flag. Missing responses are retried, and then reported as an error on bulk endpoints or as an incomplete transfer on other endpoints. An interrupt pulse marks completions and newly raised fault flags.

A three-state machine drives the sequencing. The states are IDLE (no transfer armed), ACTIVE (request presented to the engine) and NAK_HALT (armed, but held by a NAK timeout). The transitions are T_ARM (IDLE to ACTIVE on a write with bit 0 set), T_ACK, T_STALL, T_ERR and T_INC (ACTIVE to IDLE), T_NAKTO (ACTIVE to NAK_HALT) and T_RESUME (NAK_HALT to ACTIVE on a write with bit 7 at 0).

Top module: `usb_htx_ep_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and every output is low.
- R2: The read value is {bit7 NAK-timeout/incomplete, bit6 0, bit5 stalled, bit4 setup, bit3 0, bit2 error, bit1 FIFO-not-empty, bit0 ready}. Bits 6 and 3 always read 0.
- R3: Bits 7, 5 and 2 are set only by hardware. A CPU write of 0 clears them, and a write of 1 leaves them unchanged.
- R4: A write with bit 6 set forces the data toggle to 0 on the next cycle.
- R5: A STALL in ACTIVE sets bit 5, clears ready and FIFO-not-empty, and pulses the flush, DMA-abort and interrupt outputs for one cycle.
- R6: The token select output is high only while the request is high and bit 4 is set, so a write of 0x11 starts a SETUP transaction.
- R7: A write with bit 4 set forces the data toggle to 0.
- R8: An ACK in ACTIVE clears ready and the request, inverts the data toggle and pulses the interrupt.
- R9: On a bulk endpoint with limit L not 0, the L-th frame tick after the first NAK sets bit 7 and drops the request while ready stays set. A write with bit 7 at 0 resumes the request. A limit of 0 never times out.
- R10: Each transition of bit 7, 5 or 2 from 0 to 1 pulses the interrupt in the cycle it becomes visible.
- R11: On a bulk endpoint, three no-response events leave the request active. The fourth sets bit 2, clears ready, and pulses flush and interrupt.
- R12: On a non-bulk endpoint, a no-response event sets bit 7, clears ready and pulses the interrupt.
- R13: A write with bit 3 set pulses the flush output for one cycle and clears FIFO-not-empty. A FIFO load strobe sets FIFO-not-empty, and a write of 0 to bit 1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read value |
| is_bulk | input | 1 | Endpoint is a bulk endpoint |
| nak_limit | input | NAK_CW | NAK timeout in frame ticks, 0 disables |
| hs_ack | input | 1 | ACK handshake received |
| hs_nak | input | 1 | NAK handshake received |
| hs_stall | input | 1 | STALL handshake received |
| hs_noresp | input | 1 | No response from the device |
| frame_tick | input | 1 | Start-of-frame tick |
| fifo_load | input | 1 | Data written into the transmit FIFO |
| tx_req | output | 1 | Transaction request to the engine |
| tok_setup | output | 1 | 1 selects SETUP, 0 selects OUT |
| data_tog | output | 1 | Current data toggle |
| fifo_flush | output | 1 | FIFO flush strobe |
| dma_abort | output | 1 | DMA abort strobe |
| irq | output | 1 | Interrupt pulse |

## Verification
The assertions take for granted that the handshake strobes are one-hot, that each lasts one cycle and arrives only while the request is high, and that no CPU write falls in the same cycle as a handshake. The stimulus drives every handshake as an isolated one-cycle pulse after the request has been observed high. It drives register writes in quiet cycles and issues frame ticks only after a NAK has been sent. The expected register value and output vector are therefore fixed for every cycle.

// File: rtl/usb_htx_pkg.sv
package usb_htx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ACTIVE   = 2'd1,
        ST_NAK_HALT = 2'd2
    } htx_state_e;

    typedef struct packed {
        logic arm;
        logic resume;
        logic ack;
        logic stall;
        logic err;
        logic inc;
        logic nakto;
    } htx_ev_t;

    localparam int unsigned B_NAKTO  = 7;
    localparam int unsigned B_CLRTOG = 6;
    localparam int unsigned B_STALL  = 5;
    localparam int unsigned B_SETUP  = 4;
    localparam int unsigned B_FLUSH  = 3;
    localparam int unsigned B_ERR    = 2;
    localparam int unsigned B_FNE    = 1;
    localparam int unsigned B_RDY    = 0;

endpackage

// File: rtl/htx_nak_timer.sv
module htx_nak_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          nak,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] cnt_q;
    logic          seen_q;
    logic          seen_now;
    logic [CW:0]   cnt_nxt;

    assign seen_now = seen_q | nak;
    assign cnt_nxt  = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
    assign expire   = en && seen_now && tick && (limit != '0)
                      && (cnt_nxt >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (clr) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else if (en) begin
            seen_q <= seen_now;
            if (tick && seen_now && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_nxt[CW-1:0];
            end
        end
    end
endmodule

// File: rtl/htx_retry_ctr.sv
module htx_retry_ctr #(
    parameter int unsigned RETRIES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic fail,
    output logic exhausted
);
    localparam int unsigned RW = $clog2(RETRIES + 1);
    localparam logic [RW-1:0] LAST = RW'(RETRIES);

    logic [RW-1:0] cnt_q;

    assign exhausted = fail && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (fail && cnt_q != LAST) begin
            cnt_q <= cnt_q + RW'(1);
        end
    end
endmodule

// File: rtl/htx_ep_fsm.sv
module htx_ep_fsm
    import usb_htx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm_wr,
    input  logic       clr_nakto_wr,
    input  logic       hs_ack,
    input  logic       hs_stall,
    input  logic       retry_out,
    input  logic       inc_tx,
    input  logic       nak_expire,
    output htx_state_e state_q,
    output htx_ev_t    ev
);
    htx_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // event outputs per state, highest priority first
    always_comb begin
        ev = '0;
        unique case (state_q)
            ST_IDLE:     ev.arm = arm_wr;
            ST_ACTIVE: begin
                if (hs_stall)        ev.stall = 1'b1;
                else if (hs_ack)     ev.ack   = 1'b1;
                else if (retry_out)  ev.err   = 1'b1;
                else if (inc_tx)     ev.inc   = 1'b1;
                else if (nak_expire) ev.nakto = 1'b1;
            end
            ST_NAK_HALT: ev.resume = clr_nakto_wr;
            default: ;
        endcase
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (ev.arm) state_d = ST_ACTIVE;
            ST_ACTIVE: begin
                if (ev.stall || ev.ack || ev.err || ev.inc) state_d = ST_IDLE;
                else if (ev.nakto)                          state_d = ST_NAK_HALT;
            end
            ST_NAK_HALT: if (ev.resume) state_d = ST_ACTIVE;
            default:     state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/usb_htx_ep_ctrl.sv
module usb_htx_ep_ctrl
    import usb_htx_pkg::*;
#(
    parameter int unsigned NAK_CW  = 8,
    parameter int unsigned RETRIES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              is_bulk,
    input  logic [NAK_CW-1:0] nak_limit,
    input  logic              hs_ack,
    input  logic              hs_nak,
    input  logic              hs_stall,
    input  logic              hs_noresp,
    input  logic              frame_tick,
    input  logic              fifo_load,
    output logic              tx_req,
    output logic              tok_setup,
    output logic              data_tog,
    output logic              fifo_flush,
    output logic              dma_abort,
    output logic              irq
);
    htx_state_e state_q;
    htx_ev_t    ev;
    logic       active;
    logic       retry_out;
    logic       nak_expire;
    logic       cnt_clr;
    logic       flush_now;

    logic nakto_q, stall_q, setup_q, err_q, fne_q, tog_q;
    logic flush_q, abort_q, irq_q;

    assign active  = (state_q == ST_ACTIVE);
    assign cnt_clr = ev.arm | ev.ack | ev.stall | ev.err | ev.resume;

    htx_ep_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_wr      (cpu_wr & cpu_wdata[B_RDY]),
        .clr_nakto_wr(cpu_wr & ~cpu_wdata[B_NAKTO]),
        .hs_ack      (hs_ack),
        .hs_stall    (hs_stall),
        .retry_out   (retry_out),
        .inc_tx      (hs_noresp & ~is_bulk),
        .nak_expire  (nak_expire),
        .state_q     (state_q),
        .ev          (ev)
    );

    htx_retry_ctr #(.RETRIES(RETRIES)) u_retry (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .fail     (hs_noresp & is_bulk & active),
        .exhausted(retry_out)
    );

    htx_nak_timer #(.CW(NAK_CW)) u_nak (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .en    (active & is_bulk),
        .nak   (hs_nak),
        .tick  (frame_tick),
        .limit (nak_limit),
        .expire(nak_expire)
    );

    assign flush_now = (cpu_wr & cpu_wdata[B_FLUSH]) | ev.stall | ev.err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nakto_q <= 1'b0;
            stall_q <= 1'b0;
            setup_q <= 1'b0;
            err_q   <= 1'b0;
            fne_q   <= 1'b0;
            tog_q   <= 1'b0;
            flush_q <= 1'b0;
            abort_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (ev.nakto || ev.inc)                 nakto_q <= 1'b1;
            else if (cpu_wr && !cpu_wdata[B_NAKTO]) nakto_q <= 1'b0;

            if (ev.stall)                           stall_q <= 1'b1;
            else if (cpu_wr && !cpu_wdata[B_STALL]) stall_q <= 1'b0;

            if (ev.err)                             err_q <= 1'b1;
            else if (cpu_wr && !cpu_wdata[B_ERR])   err_q <= 1'b0;

            if (cpu_wr) setup_q <= cpu_wdata[B_SETUP];

            if (cpu_wr && (cpu_wdata[B_CLRTOG] || cpu_wdata[B_SETUP])) tog_q <= 1'b0;
            else if (ev.ack)                                            tog_q <= ~tog_q;

            if (flush_now)                        fne_q <= 1'b0;
            else if (fifo_load)                   fne_q <= 1'b1;
            else if (cpu_wr && !cpu_wdata[B_FNE]) fne_q <= 1'b0;

            flush_q <= flush_now;
            abort_q <= ev.stall;
            irq_q   <= ev.ack
                     | (ev.stall & ~stall_q)
                     | ((ev.nakto | ev.inc) & ~nakto_q)
                     | (ev.err & ~err_q);
        end
    end

    assign cpu_rdata  = {nakto_q, 1'b0, stall_q, setup_q, 1'b0, err_q, fne_q,
                         (state_q != ST_IDLE)};
    assign tx_req     = active;
    assign tok_setup  = active & setup_q;
    assign data_tog   = tog_q;
    assign fifo_flush = flush_q;
    assign dma_abort  = abort_q;
    assign irq        = irq_q;
endmodule

// File: rtl/usb_htx_ep_ctrl_chk.sv
module usb_htx_ep_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_wr,
    input logic wd_clrtog,
    input logic wd_stall,
    input logic wd_setup,
    input logic rd_nakto,
    input logic rd_clrtog,
    input logic rd_stall,
    input logic rd_flush,
    input logic rd_fne,
    input logic rd_rdy,
    input logic hs_ack,
    input logic hs_stall,
    input logic tx_req,
    input logic tok_setup,
    input logic data_tog,
    input logic fifo_flush,
    input logic dma_abort,
    input logic irq
);
    AST_ZERO_READ_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clrtog && !rd_flush); // R2
    AST_W0C_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !wd_stall && !hs_stall) |=> !rd_stall); // R3
    AST_CLRTOG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && wd_clrtog) |=> !data_tog); // R4
    AST_STALL_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_stall && tx_req && !cpu_wr) |=> (fifo_flush && dma_abort && rd_stall && !rd_rdy)); // R5
    AST_SETUP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        tok_setup |-> tx_req); // R6
    AST_SETUP_TOG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && wd_setup) |=> !data_tog); // R7
    AST_ACK_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_ack && tx_req && !cpu_wr) |=> (data_tog != $past(data_tog) && irq && !rd_rdy)); // R8
    AST_HALT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_nakto) |-> !tx_req); // R9
    AST_STALL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_stall) |-> irq); // R10
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |-> !rd_fne); // R13
endmodule

bind usb_htx_ep_ctrl usb_htx_ep_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_wr    (cpu_wr),
    .wd_clrtog (cpu_wdata[6]),
    .wd_stall  (cpu_wdata[5]),
    .wd_setup  (cpu_wdata[4]),
    .rd_nakto  (cpu_rdata[7]),
    .rd_clrtog (cpu_rdata[6]),
    .rd_stall  (cpu_rdata[5]),
    .rd_flush  (cpu_rdata[3]),
    .rd_fne    (cpu_rdata[1]),
    .rd_rdy    (cpu_rdata[0]),
    .hs_ack    (hs_ack),
    .hs_stall  (hs_stall),
    .tx_req    (tx_req),
    .tok_setup (tok_setup),
    .data_tog  (data_tog),
    .fifo_flush(fifo_flush),
    .dma_abort (dma_abort),
    .irq       (irq)
);

// File: tb/usb_htx_ep_ctrl_tb_top.sv
`timescale 1ns/1ps
module usb_htx_ep_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       is_bulk = 1'b1;
    logic [7:0] nak_limit = 8'd0;
    logic       hs_ack = 1'b0, hs_nak = 1'b0, hs_stall = 1'b0, hs_noresp = 1'b0;
    logic       frame_tick = 1'b0, fifo_load = 1'b0;
    logic       tx_req, tok_setup, data_tog, fifo_flush, dma_abort, irq;

    typedef struct packed {
        logic [7:0] req;
        logic [7:0] rd;
        logic [5:0] o;
    } exp_t;

    exp_t sb_q[$];
    exp_t cur;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;

    always #2.5 clk = ~clk;

    usb_htx_ep_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .is_bulk(is_bulk), .nak_limit(nak_limit),
        .hs_ack(hs_ack), .hs_nak(hs_nak), .hs_stall(hs_stall), .hs_noresp(hs_noresp),
        .frame_tick(frame_tick), .fifo_load(fifo_load), .tx_req(tx_req),
        .tok_setup(tok_setup), .data_tog(data_tog), .fifo_flush(fifo_flush),
        .dma_abort(dma_abort), .irq(irq)
    );

    // monitor: o = {tx_req, tok_setup, data_tog, fifo_flush, dma_abort, irq}
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            cur = sb_q.pop_front();
            n_chk++;
            if (cpu_rdata !== cur.rd ||
                {tx_req, tok_setup, data_tog, fifo_flush, dma_abort, irq} !== cur.o) begin
                n_bad++;
                $display("FAIL R%0d rd=%h outs=%b expected rd=%h outs=%b", cur.req, cpu_rdata,
                         {tx_req, tok_setup, data_tog, fifo_flush, dma_abort, irq}, cur.rd, cur.o);
            end
        end
    end

    // driver: inputs already set; expectation for the cycle after the next edge
    task automatic step(input int r, input logic [7:0] rd, input logic [5:0] o);
        @(posedge clk);
        #1;
        sb_q.push_back('{req: 8'(r), rd: rd, o: o});
        @(negedge clk);
        cpu_wr = 1'b0; hs_ack = 1'b0; hs_nak = 1'b0; hs_stall = 1'b0;
        hs_noresp = 1'b0; frame_tick = 1'b0; fifo_load = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d, input int r, input logic [7:0] rd, input logic [5:0] o);
        cpu_wr = 1'b1; cpu_wdata = d;
        step(r, rd, o);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        step(1, 8'h00, 6'b000000);                 // R1 reset state

        wr(8'h01, 8, 8'h01, 6'b100000);            // R8 arm OUT
        hs_ack = 1'b1; step(8, 8'h00, 6'b001001);  // R8 ack flips toggle
        step(8, 8'h00, 6'b001000);
        wr(8'h40, 4, 8'h00, 6'b000000);            // R4 clear toggle, R2 bit6 reads 0

        wr(8'h01, 8, 8'h01, 6'b100000);
        hs_ack = 1'b1; step(8, 8'h00, 6'b001001);
        wr(8'h11, 6, 8'h11, 6'b110000);            // R6 SETUP token, R7 toggle forced 0
        hs_ack = 1'b1; step(7, 8'h10, 6'b001001);  // R7
        wr(8'h00, 6, 8'h00, 6'b001000);

        fifo_load = 1'b1; step(13, 8'h02, 6'b001000);
        wr(8'h03, 5, 8'h03, 6'b101000);
        hs_stall = 1'b1; step(5, 8'h20, 6'b001111); // R5 and R10 stall
        wr(8'hA4, 3, 8'h20, 6'b001000);            // R3 write 1 has no effect
        wr(8'h00, 3, 8'h00, 6'b001000);            // R3 write 0 clears

        fifo_load = 1'b1; step(13, 8'h02, 6'b001000);
        wr(8'h0A, 13, 8'h00, 6'b001100);           // R13 flush
        step(13, 8'h00, 6'b001000);

        nak_limit = 8'd3;
        wr(8'h01, 9, 8'h01, 6'b101000);
        hs_nak = 1'b1; step(9, 8'h01, 6'b101000);
        frame_tick = 1'b1; step(9, 8'h01, 6'b101000);
        frame_tick = 1'b1; step(9, 8'h01, 6'b101000);
        frame_tick = 1'b1; step(9, 8'h81, 6'b001001); // R9 halt, R10 irq
        wr(8'h01, 9, 8'h01, 6'b101000);            // R9 resume
        hs_ack = 1'b1; step(8, 8'h00, 6'b000001);

        nak_limit = 8'd0;
        wr(8'h01, 9, 8'h01, 6'b100000);
        hs_nak = 1'b1; step(9, 8'h01, 6'b100000);
        for (int i = 0; i < 5; i++) begin
            frame_tick = 1'b1; step(9, 8'h01, 6'b100000); // R9 limit 0 disabled
        end
        hs_ack = 1'b1; step(8, 8'h00, 6'b001001);

        wr(8'h01, 11, 8'h01, 6'b101000);
        for (int i = 0; i < 3; i++) begin
            hs_noresp = 1'b1; step(11, 8'h01, 6'b101000); // R11 retries
        end
        hs_noresp = 1'b1; step(11, 8'h04, 6'b001101); // R11 error
        wr(8'h00, 3, 8'h00, 6'b001000);

        is_bulk = 1'b0;
        wr(8'h01, 12, 8'h01, 6'b101000);
        hs_noresp = 1'b1; step(12, 8'h80, 6'b001001); // R12 incomplete
        wr(8'h00, 12, 8'h00, 6'b001000);

        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule